// File: doc/BRIEF.md
# Multi-Mode Memory Channel Distributor

The distributor sits between one upstream port that carries whole 64-byte cache lines and four downstream memory channel ports. The channels form two fixed pairs: channels 0 and 1, and channels 2 and 3. Each pair has its own 2-bit pairing policy, and this policy decides how a line is spread over the two channels.

In independent mode a single channel moves the whole line as eight 8-byte beats. In lockstep mode the line is split into two 32-byte halves, and both channels of the pair get the same address in the same cycle. In mirror mode every write is copied to both channels of the pair, and reads are served by the primary (even) channel only.

Read data is collected into 32-byte units before it goes upstream. Responses come back in the order the requests were accepted, and the final unit of each line is marked. A write is acknowledged upstream only after every channel it went to has reported completion. The policy is sampled when a request is accepted, so software changes it only while the pair is idle.

Top module: `mem_chan_distrib`

## Requirements
- R1: After reset, no channel beat is valid, no response is valid, and the upstream port is ready.
- R2: Independent write (policy 00). The pair is selected by address bit 7, and bit 6 selects the odd (1) or even (0) channel. That channel receives eight beats with write=1, the line address and length field 7. Beat k carries write-data bits [64k+63:64k], and the last flag is set on beat 8 only. Every other channel stays idle.
- R3: Two independent writes to the same channel, with all ready inputs high, produce 16 beats on 16 consecutive cycles.
- R4: Lockstep write (policy 01). Both channels of the pair start in the same cycle with the same address and length field 3, four beats each. The even channel carries bytes 0-31 (beat k = bits [64k+63:64k]). The odd channel carries bytes 32-63 (beat k = bits [256+64k+63:256+64k]).
- R5: Mirror write (policy 10). Both channels of the pair receive the full eight-beat line, identical to the independent beat layout, whatever the value of bit 6.
- R6: A write response has is_wr=1 and last=1. It is returned only after every channel that took the write has pulsed its completion input. In lockstep and mirror modes, a completion from one channel alone returns nothing.
- R7: Independent read. The selected channel receives one command beat with write=0, last=1 and length field 7. The eight returned beats go upstream as two 32-byte units, with the first returned beat in the lowest bits. The first unit has last=0 and the second has last=1.
- R8: Lockstep read. Both channels receive one command beat with length field 3. The first unit is taken from the even channel and the second, with last=1, from the odd channel. This order holds even when the odd channel's data arrives first.
- R9: Mirror read. Only the even channel of the pair receives a command, and the line returns as two units from that channel.
- R10: Policy code 11 behaves exactly as independent mode.
- R11: A request is accepted only when every channel it targets can take it in the same cycle. While a target channel is stalled, the upstream ready is low and the stalled beat holds still.
- R12: Responses follow the order in which requests were accepted. A response stalled by the upstream ready holds its data and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2*NUM_PAIRS | Pairing policy per pair, 2 bits each |
| req_valid | input | 1 | Line request valid |
| req_ready | output | 1 | Line request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Line-aligned byte address |
| req_wdata | input | BEAT_W*LINE_BEATS | Whole line of write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_is_wr | output | 1 | Response is a write acknowledge |
| rsp_last | output | 1 | Final unit of the line |
| rsp_data | output | BEAT_W*LINE_BEATS/2 | 32-byte read unit |
| ch_valid | output | NUM_CH | Channel beat valid |
| ch_ready | input | NUM_CH | Channel beat taken |
| ch_write | output | NUM_CH | Channel beat is a write |
| ch_addr | output | NUM_CH*ADDR_W | Channel address |
| ch_len | output | NUM_CH*log2(LINE_BEATS) | Burst length minus one |
| ch_wdata | output | NUM_CH*BEAT_W | Channel write beat |
| ch_last | output | NUM_CH | Last beat of a command |
| ch_rvalid | input | NUM_CH | Channel read beat valid |
| ch_rready | output | NUM_CH | Channel read beat taken |
| ch_rdata | input | NUM_CH*BEAT_W | Channel read beat |
| ch_bvalid | input | NUM_CH | One-cycle write completion pulse |

## Verification
The first channel beat appears in the cycle after the upstream handshake. A write burst therefore ends eight cycles later, and a lockstep burst four cycles later. A write response is handshaken on the second rising edge after the last required completion pulse. A read unit leaves on the edge after its fourth beat is accepted. The bench drives inputs on the falling edge and waits windows longer than these latencies before it inspects its logs. Each logged beat carries a cycle stamp, so back-to-back issue and same-cycle lockstep issue are checked directly. Negative checks (no response after one of two completions, no early unit) wait at least as long as the positive latency before they look.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

   typedef enum logic [1:0] {
      PM_INDEP  = 2'b00,
      PM_LOCK   = 2'b01,
      PM_MIRROR = 2'b10,
      PM_RSVD   = 2'b11
   } pair_mode_e;

   function automatic pair_mode_e mode_resolve(input logic [1:0] raw);
      return (raw == 2'b11) ? PM_INDEP : pair_mode_e'(raw);
   endfunction

endpackage

// File: rtl/mcd_beat_ser.sv
module mcd_beat_ser #(
   parameter int ADDR_W     = 32,
   parameter int BEAT_W     = 64,
   parameter int LINE_BEATS = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         ld_en,
   input  logic                         ld_write,
   input  logic [ADDR_W-1:0]            ld_addr,
   input  logic [$clog2(LINE_BEATS)-1:0] ld_len,
   input  logic [BEAT_W*LINE_BEATS-1:0] ld_data,
   output logic                         can_load,
   output logic                         o_valid,
   input  logic                         o_ready,
   output logic                         o_write,
   output logic [ADDR_W-1:0]            o_addr,
   output logic [$clog2(LINE_BEATS)-1:0] o_len,
   output logic [BEAT_W-1:0]            o_data,
   output logic                         o_last
);
   localparam int LEN_W  = $clog2(LINE_BEATS);
   localparam int LINE_W = BEAT_W * LINE_BEATS;

   logic              busy_q;
   logic [LEN_W-1:0]  cnt_q;
   logic              wr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  len_q;
   logic [LINE_W-1:0] data_q;
   logic              fire;
   logic              done;

   assign o_valid  = busy_q;
   assign o_write  = wr_q;
   assign o_addr   = addr_q;
   assign o_len    = len_q;
   assign o_data   = data_q[cnt_q*BEAT_W +: BEAT_W];
   assign o_last   = !wr_q || (cnt_q == len_q);
   assign fire     = busy_q && o_ready;
   assign done     = fire && o_last;
   assign can_load = !busy_q || done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         wr_q   <= 1'b0;
         addr_q <= '0;
         len_q  <= '0;
         data_q <= '0;
      end else if (ld_en) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
         wr_q   <= ld_write;
         addr_q <= ld_addr;
         len_q  <= ld_len;
         data_q <= ld_data;
      end else if (done) begin
         busy_q <= 1'b0;
      end else if (fire) begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   // R11
   ser_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |-> can_load);

   // R11
   ser_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !o_ready) |=> (busy_q && $stable(o_data) && $stable(o_addr) && $stable(o_last)));

endmodule

// File: rtl/mcd_unit_gather.sv
module mcd_unit_gather #(
   parameter int BEAT_W = 64,
   parameter int HALF   = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     i_valid,
   output logic                     i_ready,
   input  logic [BEAT_W-1:0]        i_data,
   output logic                     u_valid,
   output logic [BEAT_W*HALF-1:0]   u_data,
   input  logic                     u_take
);
   localparam int IDX_W = $clog2(HALF);
   localparam int CNT_W = IDX_W + 1;

   logic [CNT_W-1:0]  cnt_q;
   logic [BEAT_W-1:0] beat_q [HALF];

   assign u_valid = (cnt_q == CNT_W'(HALF));
   assign i_ready = !u_valid;

   for (genvar k = 0; k < HALF; k++) begin : g_pack
      assign u_data[k*BEAT_W +: BEAT_W] = beat_q[k];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (u_take) begin
         cnt_q <= '0;
      end else if (i_valid && i_ready) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (i_valid && i_ready) begin
         beat_q[cnt_q[IDX_W-1:0]] <= i_data;
      end
   end

   // R7
   gat_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      u_take |-> u_valid);

endmodule

// File: rtl/mem_chan_distrib.sv
module mem_chan_distrib
   import mcd_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int BEAT_W     = 64,
   parameter int LINE_BEATS = 8,
   parameter int NUM_PAIRS  = 2,
   parameter int TRK_DEPTH  = 4
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic [2*NUM_PAIRS-1:0]                    cfg_mode,
   input  logic                                      req_valid,
   output logic                                      req_ready,
   input  logic                                      req_write,
   input  logic [ADDR_W-1:0]                         req_addr,
   input  logic [BEAT_W*LINE_BEATS-1:0]              req_wdata,
   output logic                                      rsp_valid,
   input  logic                                      rsp_ready,
   output logic                                      rsp_is_wr,
   output logic                                      rsp_last,
   output logic [BEAT_W*(LINE_BEATS/2)-1:0]          rsp_data,
   output logic [2*NUM_PAIRS-1:0]                    ch_valid,
   input  logic [2*NUM_PAIRS-1:0]                    ch_ready,
   output logic [2*NUM_PAIRS-1:0]                    ch_write,
   output logic [2*NUM_PAIRS*ADDR_W-1:0]             ch_addr,
   output logic [2*NUM_PAIRS*$clog2(LINE_BEATS)-1:0] ch_len,
   output logic [2*NUM_PAIRS*BEAT_W-1:0]             ch_wdata,
   output logic [2*NUM_PAIRS-1:0]                    ch_last,
   input  logic [2*NUM_PAIRS-1:0]                    ch_rvalid,
   output logic [2*NUM_PAIRS-1:0]                    ch_rready,
   input  logic [2*NUM_PAIRS*BEAT_W-1:0]             ch_rdata,
   input  logic [2*NUM_PAIRS-1:0]                    ch_bvalid
);
   localparam int NUM_CH = 2 * NUM_PAIRS;
   localparam int LINE_W = BEAT_W * LINE_BEATS;
   localparam int HALF   = LINE_BEATS / 2;
   localparam int UNIT_W = BEAT_W * HALF;
   localparam int LEN_W  = $clog2(LINE_BEATS);
   localparam int OFF_W  = $clog2(LINE_W / 8);
   localparam int PAIR_W = $clog2(NUM_PAIRS);
   localparam int CH_W   = $clog2(NUM_CH);
   localparam int TRK_AW = $clog2(TRK_DEPTH);
   localparam int ACK_W  = $clog2(TRK_DEPTH + 1);

   if (LINE_BEATS < 4 || (LINE_BEATS & (LINE_BEATS - 1)) != 0) begin : g_bad_beats
      $error("LINE_BEATS must be a power of two of at least 4");
   end
   if (NUM_PAIRS < 2 || (NUM_PAIRS & (NUM_PAIRS - 1)) != 0) begin : g_bad_pairs
      $error("NUM_PAIRS must be a power of two of at least 2");
   end
   if (TRK_DEPTH < 2 || (TRK_DEPTH & (TRK_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("TRK_DEPTH must be a power of two of at least 2");
   end
   if (BEAT_W % 8 != 0 || ADDR_W <= OFF_W + PAIR_W) begin : g_bad_width
      $error("BEAT_W must be whole bytes and ADDR_W must cover the pair select");
   end

   typedef struct packed {
      logic              wr;
      logic [CH_W-1:0]   s0;
      logic [CH_W-1:0]   s1;
      logic [NUM_CH-1:0] am;
   } trk_t;

   // request decode
   logic [PAIR_W-1:0] rq_pair;
   logic              rq_sel;
   pair_mode_e        rq_mode;
   logic [NUM_CH-1:0] tgt;
   logic [CH_W-1:0]   rq_s0, rq_s1;
   logic [NUM_CH-1:0] can_load;
   logic              trk_full;
   logic              acc;

   assign rq_pair = req_addr[OFF_W+1 +: PAIR_W];
   assign rq_sel  = req_addr[OFF_W];
   assign rq_mode = mode_resolve(cfg_mode[rq_pair*2 +: 2]);

   always_comb begin
      tgt   = '0;
      rq_s0 = {rq_pair, rq_sel};
      rq_s1 = {rq_pair, rq_sel};
      case (rq_mode)
         PM_LOCK: begin
            tgt[{rq_pair, 1'b0}] = 1'b1;
            tgt[{rq_pair, 1'b1}] = 1'b1;
            rq_s0 = {rq_pair, 1'b0};
            rq_s1 = {rq_pair, 1'b1};
         end
         PM_MIRROR: begin
            tgt[{rq_pair, 1'b0}] = 1'b1;
            tgt[{rq_pair, 1'b1}] = req_write;
            rq_s0 = {rq_pair, 1'b0};
            rq_s1 = {rq_pair, 1'b0};
         end
         default: begin
            tgt[{rq_pair, rq_sel}] = 1'b1;
         end
      endcase
   end

   assign req_ready = !trk_full && (&(~tgt | can_load));
   assign acc       = req_valid && req_ready;

   // per-channel datapath
   logic [UNIT_W-1:0] u_data [NUM_CH];
   logic [NUM_CH-1:0] u_valid;
   logic [NUM_CH-1:0] u_take;
   logic [NUM_CH-1:0] ack_dec;
   logic [NUM_CH-1:0] ack_nz;
   logic [ACK_W-1:0]  ack_cnt [NUM_CH];
   logic [CH_W-1:0]   src;
   logic              rsp_fire;
   trk_t              hd;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [LINE_W-1:0] ld_data;
      logic [LEN_W-1:0]  ld_len;

      assign ld_len = (rq_mode == PM_LOCK) ? LEN_W'(HALF - 1) : LEN_W'(LINE_BEATS - 1);

      if (c % 2 == 1) begin : g_odd
         assign ld_data = (rq_mode == PM_LOCK) ?
                          {{UNIT_W{1'b0}}, req_wdata[LINE_W-1 -: UNIT_W]} : req_wdata;
      end else begin : g_even
         assign ld_data = req_wdata;
      end

      mcd_beat_ser #(
         .ADDR_W     (ADDR_W),
         .BEAT_W     (BEAT_W),
         .LINE_BEATS (LINE_BEATS)
      ) ser_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .ld_en    (acc && tgt[c]),
         .ld_write (req_write),
         .ld_addr  (req_addr),
         .ld_len   (ld_len),
         .ld_data  (ld_data),
         .can_load (can_load[c]),
         .o_valid  (ch_valid[c]),
         .o_ready  (ch_ready[c]),
         .o_write  (ch_write[c]),
         .o_addr   (ch_addr[c*ADDR_W +: ADDR_W]),
         .o_len    (ch_len[c*LEN_W +: LEN_W]),
         .o_data   (ch_wdata[c*BEAT_W +: BEAT_W]),
         .o_last   (ch_last[c])
      );

      mcd_unit_gather #(
         .BEAT_W (BEAT_W),
         .HALF   (HALF)
      ) gat_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .i_valid (ch_rvalid[c]),
         .i_ready (ch_rready[c]),
         .i_data  (ch_rdata[c*BEAT_W +: BEAT_W]),
         .u_valid (u_valid[c]),
         .u_data  (u_data[c]),
         .u_take  (u_take[c])
      );

      assign u_take[c]  = rsp_fire && !hd.wr && (src == CH_W'(c));
      assign ack_dec[c] = rsp_fire && hd.wr && hd.am[c];
      assign ack_nz[c]  = (ack_cnt[c] != '0);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ack_cnt[c] <= '0;
         end else begin
            ack_cnt[c] <= ack_cnt[c] + ACK_W'(ch_bvalid[c]) - ACK_W'(ack_dec[c]);
         end
      end

      // R6
      ack_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_cnt[c] == ACK_W'(TRK_DEPTH)) |-> !ch_bvalid[c]);
   end

   // in-order tracking of accepted requests
   trk_t              trk_q [TRK_DEPTH];
   logic [TRK_AW-1:0] wr_ptr, rd_ptr;
   logic [TRK_AW:0]   trk_cnt;
   logic              phase_q;
   logic              hd_vld;
   logic              ack_ok;
   logic              pop;

   assign trk_full = (trk_cnt == (TRK_AW+1)'(TRK_DEPTH));
   assign hd       = trk_q[rd_ptr];
   assign hd_vld   = (trk_cnt != '0);
   assign src      = phase_q ? hd.s1 : hd.s0;
   assign ack_ok   = &(~hd.am | ack_nz);

   assign rsp_valid = hd_vld && (hd.wr ? ack_ok : u_valid[src]);
   assign rsp_is_wr = hd.wr;
   assign rsp_last  = hd.wr || phase_q;
   assign rsp_data  = hd.wr ? '0 : u_data[src];
   assign rsp_fire  = rsp_valid && rsp_ready;
   assign pop       = rsp_fire && rsp_last;

   always_ff @(posedge clk) begin
      if (acc) begin
         trk_q[wr_ptr] <= '{wr: req_write, s0: rq_s0, s1: rq_s1,
                            am: (req_write ? tgt : '0)};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         trk_cnt <= '0;
         phase_q <= 1'b0;
      end else begin
         if (acc) wr_ptr <= wr_ptr + 1'b1;
         if (pop) rd_ptr <= rd_ptr + 1'b1;
         trk_cnt <= trk_cnt + (TRK_AW+1)'(acc) - (TRK_AW+1)'(pop);
         if (pop)           phase_q <= 1'b0;
         else if (rsp_fire) phase_q <= 1'b1;
      end
   end

   // R12
   rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=>
         (rsp_valid && $stable(rsp_data) && $stable(rsp_last) && $stable(rsp_is_wr)));

endmodule

// File: tb/mem_chan_distrib_tb_top.sv
module mem_chan_distrib_tb_top;
   localparam int NCH = 4;
   localparam int AW  = 32;
   localparam int BW  = 64;
   localparam int LW  = 512;
   localparam int UW  = 256;

   typedef struct packed {
      logic          wr;
      logic [AW-1:0] addr;
      logic [2:0]    len;
      logic [BW-1:0] d;
      logic          last;
      logic [31:0]   cyc;
   } beat_t;

   typedef struct packed {
      logic          is_wr;
      logic          last;
      logic [UW-1:0] d;
   } rsp_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [3:0]      cfg_mode = 4'b0000;
   logic            req_valid = 1'b0;
   logic            req_ready;
   logic            req_write = 1'b0;
   logic [AW-1:0]   req_addr = '0;
   logic [LW-1:0]   req_wdata = '0;
   logic            rsp_valid;
   logic            rsp_ready = 1'b1;
   logic            rsp_is_wr;
   logic            rsp_last;
   logic [UW-1:0]   rsp_data;
   logic [NCH-1:0]  ch_valid;
   logic [NCH-1:0]  ch_ready = '1;
   logic [NCH-1:0]  ch_write;
   logic [NCH*AW-1:0] ch_addr;
   logic [NCH*3-1:0]  ch_len;
   logic [NCH*BW-1:0] ch_wdata;
   logic [NCH-1:0]  ch_last;
   logic [NCH-1:0]  ch_rvalid = '0;
   logic [NCH-1:0]  ch_rready;
   logic [NCH*BW-1:0] ch_rdata = '0;
   logic [NCH-1:0]  ch_bvalid = '0;

   int unsigned n_cmp = 0;
   int unsigned n_bad = 0;
   logic [31:0] cyc = 0;
   bit          finished = 0;

   beat_t chlog [NCH][$];
   rsp_t  rlog [$];

   always #2 clk = ~clk;

   mem_chan_distrib dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_is_wr(rsp_is_wr),
      .rsp_last(rsp_last), .rsp_data(rsp_data),
      .ch_valid(ch_valid), .ch_ready(ch_ready), .ch_write(ch_write),
      .ch_addr(ch_addr), .ch_len(ch_len), .ch_wdata(ch_wdata), .ch_last(ch_last),
      .ch_rvalid(ch_rvalid), .ch_rready(ch_rready), .ch_rdata(ch_rdata),
      .ch_bvalid(ch_bvalid)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            if (ch_valid[c] && ch_ready[c])
               chlog[c].push_back(beat_t'{wr: ch_write[c], addr: ch_addr[c*AW +: AW],
                                          len: ch_len[c*3 +: 3], d: ch_wdata[c*BW +: BW],
                                          last: ch_last[c], cyc: cyc});
         end
         if (rsp_valid && rsp_ready)
            rlog.push_back(rsp_t'{is_wr: rsp_is_wr, last: rsp_last, d: rsp_data});
      end
   end

   function automatic logic [LW-1:0] line_pat(input logic [15:0] seed);
      logic [LW-1:0] v;
      for (int k = 0; k < 8; k++) v[k*BW +: BW] = {16'hA5C3, seed, 24'h0, 8'(k)};
      return v;
   endfunction

   function automatic logic [BW-1:0] rd_pat(input int c, input int k);
      return {32'hD00D_0000 | 32'(c), 32'h0000_1000 | 32'(k)};
   endfunction

   function automatic logic [UW-1:0] unit_exp(input int c, input int off);
      logic [UW-1:0] v;
      for (int k = 0; k < 4; k++) v[k*BW +: BW] = rd_pat(c, off + k);
      return v;
   endfunction

   task automatic chk(input string rq, input logic [UW-1:0] act, input logic [UW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_logs();
      for (int c = 0; c < NCH; c++) chlog[c].delete();
      rlog.delete();
   endtask

   task automatic send(input logic wr, input logic [AW-1:0] addr, input logic [LW-1:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = d;
      #1;
      while (!req_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic pulse_b(input int c);
      @(negedge clk); ch_bvalid[c] = 1'b1;
      @(negedge clk); ch_bvalid[c] = 1'b0;
   endtask

   task automatic drive_rd(input int c, input int n, input int off);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         ch_rvalid[c] = 1'b1;
         ch_rdata[c*BW +: BW] = rd_pat(c, off + k);
         #1;
         while (!ch_rready[c]) begin @(negedge clk); #1; end
         @(posedge clk);
      end
      @(negedge clk);
      ch_rvalid[c] = 1'b0;
   endtask

   task automatic chk_burst(input string rq, input int c, input int idx0, input int nb,
                            input logic wr, input logic [AW-1:0] addr,
                            input logic [LW-1:0] v, input int boff);
      chk({rq, " beat count"}, UW'(chlog[c].size() >= idx0 + nb), UW'(1));
      if (chlog[c].size() < idx0 + nb) return;
      for (int k = 0; k < nb; k++) begin
         beat_t b = chlog[c][idx0 + k];
         chk({rq, " write"}, UW'(b.wr), UW'(wr));
         chk({rq, " addr"}, UW'(b.addr), UW'(addr));
         chk({rq, " len"}, UW'(b.len), UW'(nb - 1));
         chk({rq, " data"}, UW'(b.d), UW'(v[(boff + k)*BW +: BW]));
         chk({rq, " last"}, UW'(b.last), UW'(k == nb - 1));
      end
   endtask

   task automatic chk_cmd(input string rq, input int c, input logic [AW-1:0] addr, input int len);
      chk({rq, " cmd count"}, UW'(chlog[c].size()), UW'(1));
      if (chlog[c].size() != 1) return;
      chk({rq, " cmd write"}, UW'(chlog[c][0].wr), UW'(0));
      chk({rq, " cmd addr"}, UW'(chlog[c][0].addr), UW'(addr));
      chk({rq, " cmd len"}, UW'(chlog[c][0].len), UW'(len));
      chk({rq, " cmd last"}, UW'(chlog[c][0].last), UW'(1));
   endtask

   task automatic chk_units(input string rq, input int c0, input int o0, input int c1, input int o1);
      chk({rq, " unit count"}, UW'(rlog.size()), UW'(2));
      if (rlog.size() != 2) return;
      chk({rq, " unit0 data"}, rlog[0].d, unit_exp(c0, o0));
      chk({rq, " unit0 flags"}, UW'({rlog[0].is_wr, rlog[0].last}), UW'(2'b00));
      chk({rq, " unit1 data"}, rlog[1].d, unit_exp(c1, o1));
      chk({rq, " unit1 flags"}, UW'({rlog[1].is_wr, rlog[1].last}), UW'(2'b01));
   endtask

   task automatic chk_wack(input string rq, input int n);
      chk({rq, " ack count"}, UW'(rlog.size()), UW'(n));
      for (int i = 0; i < rlog.size(); i++)
         chk({rq, " ack flags"}, UW'({rlog[i].is_wr, rlog[i].last}), UW'(2'b11));
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 ch_valid", UW'(ch_valid), UW'(0));
      chk("R1 rsp_valid", UW'(rsp_valid), UW'(0));
      chk("R1 req_ready", UW'(req_ready), UW'(1));
   endtask

   task automatic t_indep_write();
      logic [LW-1:0] d = line_pat(16'h0001);
      clear_logs();
      send(1'b1, 32'h0000_0040, d);
      tick(12);
      chk_burst("R2 indep write", 1, 0, 8, 1'b1, 32'h40, d, 0);
      chk("R2 other channels idle", UW'(chlog[0].size() + chlog[2].size() + chlog[3].size()), UW'(0));
      pulse_b(1);
      tick(3);
      chk_wack("R6 indep ack", 1);
   endtask

   task automatic t_back_to_back();
      logic [LW-1:0] a = line_pat(16'h0002);
      logic [LW-1:0] b = line_pat(16'h0003);
      clear_logs();
      send(1'b1, 32'h0000_0000, a);
      send(1'b1, 32'h0000_0100, b);
      tick(20);
      chk_burst("R3 first burst", 0, 0, 8, 1'b1, 32'h0, a, 0);
      chk_burst("R3 second burst", 0, 8, 8, 1'b1, 32'h100, b, 0);
      if (chlog[0].size() == 16)
         chk("R3 no idle cycle", UW'(chlog[0][15].cyc - chlog[0][0].cyc), UW'(15));
      pulse_b(0);
      pulse_b(0);
      tick(3);
      chk_wack("R6 two acks", 2);
   endtask

   task automatic t_lock_write();
      logic [LW-1:0] d = line_pat(16'h0004);
      clear_logs();
      @(negedge clk); cfg_mode = 4'b0100;
      send(1'b1, 32'h0000_0080, d);
      tick(8);
      chk_burst("R4 lock even half", 2, 0, 4, 1'b1, 32'h80, d, 0);
      chk_burst("R4 lock odd half", 3, 0, 4, 1'b1, 32'h80, d, 4);
      if (chlog[2].size() > 0 && chlog[3].size() > 0)
         chk("R4 same start cycle", UW'(chlog[2][0].cyc), UW'(chlog[3][0].cyc));
      pulse_b(2);
      tick(4);
      chk("R6 lock one ack only", UW'(rlog.size()), UW'(0));
      pulse_b(3);
      tick(3);
      chk_wack("R6 lock both acks", 1);
   endtask

   task automatic t_mirror_write();
      logic [LW-1:0] d = line_pat(16'h0005);
      clear_logs();
      @(negedge clk); cfg_mode = 4'b0110;
      send(1'b1, 32'h0000_0040, d);
      tick(12);
      chk_burst("R5 mirror primary", 0, 0, 8, 1'b1, 32'h40, d, 0);
      chk_burst("R5 mirror copy", 1, 0, 8, 1'b1, 32'h40, d, 0);
      pulse_b(0);
      tick(4);
      chk("R6 mirror one ack only", UW'(rlog.size()), UW'(0));
      pulse_b(1);
      tick(3);
      chk_wack("R6 mirror both acks", 1);
   endtask

   task automatic t_indep_read();
      clear_logs();
      @(negedge clk); cfg_mode = 4'b0100;
      send(1'b0, 32'h0000_0040, '0);
      tick(3);
      chk_cmd("R7 indep read", 1, 32'h40, 7);
      drive_rd(1, 8, 0);
      tick(4);
      chk_units("R7 indep read", 1, 0, 1, 4);
   endtask

   task automatic t_lock_read();
      clear_logs();
      send(1'b0, 32'h0000_0080, '0);
      tick(3);
      chk_cmd("R8 lock read even", 2, 32'h80, 3);
      chk_cmd("R8 lock read odd", 3, 32'h80, 3);
      drive_rd(3, 4, 0);
      tick(4);
      chk("R12 no early odd unit", UW'(rlog.size()), UW'(0));
      drive_rd(2, 4, 0);
      tick(4);
      chk_units("R8 R12 lock read order", 2, 0, 3, 0);
   endtask

   task automatic t_mirror_read();
      clear_logs();
      @(negedge clk); cfg_mode = 4'b0110;
      send(1'b0, 32'h0000_0040, '0);
      tick(3);
      chk_cmd("R9 mirror read primary", 0, 32'h40, 7);
      chk("R9 partner idle", UW'(chlog[1].size()), UW'(0));
      drive_rd(0, 8, 0);
      tick(4);
      chk_units("R9 mirror read", 0, 0, 0, 4);
   endtask

   task automatic t_reserved();
      logic [LW-1:0] d = line_pat(16'h0006);
      clear_logs();
      @(negedge clk); cfg_mode = 4'b0111;
      send(1'b1, 32'h0000_0040, d);
      tick(12);
      chk_burst("R10 reserved as indep", 1, 0, 8, 1'b1, 32'h40, d, 0);
      chk("R10 partner idle", UW'(chlog[0].size()), UW'(0));
      pulse_b(1);
      tick(3);
      chk_wack("R10 reserved ack", 1);
   endtask

   task automatic t_stall();
      logic [LW-1:0] a = line_pat(16'h0007);
      logic [LW-1:0] b = line_pat(16'h0008);
      clear_logs();
      @(negedge clk); cfg_mode = 4'b0100; ch_ready[3] = 1'b0;
      send(1'b1, 32'h0000_0080, a);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 32'h0000_0180; req_wdata = b;
      tick(6);
      #1;
      chk("R11 ready low while stalled", UW'(req_ready), UW'(0));
      chk("R11 stalled channel silent", UW'(chlog[3].size()), UW'(0));
      chk("R11 stalled beat held", UW'(ch_wdata[3*BW +: BW]), UW'(a[4*BW +: BW]));
      @(negedge clk); ch_ready[3] = 1'b1;
      #1;
      while (!req_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      @(negedge clk); req_valid = 1'b0;
      tick(12);
      chk_burst("R11 odd first", 3, 0, 4, 1'b1, 32'h80, a, 4);
      chk_burst("R11 odd second", 3, 4, 4, 1'b1, 32'h180, b, 4);
      chk_burst("R11 even second", 2, 4, 4, 1'b1, 32'h180, b, 0);
      pulse_b(2); pulse_b(3); pulse_b(2); pulse_b(3);
      tick(3);
      chk_wack("R12 stall acks", 2);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_indep_write();
      t_back_to_back();
      t_lock_write();
      t_mirror_write();
      t_indep_read();
      t_lock_read();
      t_mirror_read();
      t_reserved();
      t_stall();
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog R12 act=hung exp=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule